// File: doc/BRIEF.md
# Looping Descriptor DMA Channel

This block is a single DMA channel that streams data between a memory buffer and one fixed peripheral data register. It takes its work from a chain of 32-byte descriptors held in memory. Each descriptor names a source, a destination, a byte count and the address of the next descriptor. The chain is normally closed into a ring. The channel walks that ring again and again until software aborts it. This lets software keep two descriptors alive and refill the one that has just finished, while the other one runs.

Software reaches a small register port: a mode word, a status word with write-one-to-clear flags, the address of the first descriptor, and read-only views of the latest source address, the latest destination address and the bytes left in the segment. A single memory master port fetches descriptors and moves data. A pacing input lets the peripheral decide when each burst may start. The channel raises an interrupt at each segment boundary and on errors.

Top module: `chdma_channel`

## Requirements
- R1: After reset the status word, both current-address views, the bytes-left view and the mode word read as zero, `irq` is low and `mem_req` is low.
- R2: A descriptor at address D is read as three 8-byte little-endian beats: D+0 gives the source in bits 31:0 and the destination in bits 63:32. D+8 gives the byte count in bits 31:0. D+16 gives the next pointer, whose low ADDR_W bits are used. Segments move in chain order and the ring repeats until aborted.
- R3: The segment flag (status bit 0) is set when a descriptor's last unit has been written. With the segment interrupt enable (mode bit 2) set, `irq` follows it, giving one interrupt per descriptor on every pass of the ring.
- R4: The loop flag (status bit 1) is set when a segment completes whose next pointer equals the first-descriptor register (register 2).
- R5: Mode bits 7:6 give log2 of the unit size (1, 2, 4 or 8 bytes). Mode bit 4 holds the source address and mode bit 5 holds the destination address; a held address is not advanced between units. Mode bits 11:1 read back, while the abort bit (0) and the go bit (12) read as zero.
- R6: Mode bits 11:8 give log2 of the burst length in bytes. With pacing (mode bit 1) set, a burst starts only after `periph_req` is seen high at a burst boundary. A burst then moves the full burst length, or stops early at the end of the segment.
- R7: In the status word (register 1), bits 0 to 3 clear when 1 is written to them and are unchanged when 0 is written. A flag set in the same cycle as a clear of that flag stays set.
- R8: Writing the mode word with bit 0 set stops the channel at once. After that there are no further memory requests, the busy bit drops and the bytes-left view (register 5) reads zero.
- R9: The current-source view (register 3) and the current-destination view (register 4) read zero until the first data transfer. After that they hold the address of the most recent data read and the most recent data write.
- R10: Status bit 2 is set, and the channel halts, in any of these cases: the first descriptor address is not 32-byte aligned when go is written; a descriptor count is zero or not a multiple of the unit size; a next pointer is not 32-byte aligned; or the mode word is written with pacing set while the channel is busy with a nonzero byte count. This error drives `irq` only when the error interrupt enable (mode bit 3) is set.
- R11: A beat answered with `mem_err` sets status bit 3 and halts the channel before any further beat. This error drives `irq` when mode bit 3 is set.
- R12: Status bit 4 (busy) is 1 from go until an abort or a halt on error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mode, 1 status, 2 first descriptor, 3 current source, 4 current destination, 5 bytes left |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| periph_req | input | 1 | Peripheral allows the next burst |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_size | output | 2 | log2 of the beat size in bytes |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_rdata | input | 64 | Read data, right-aligned |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | Beat failed, valid with `mem_ack` |
| irq | output | 1 | Interrupt |

## Verification
The cycle in which a segment ends and sets its flag can coincide with a software write that clears the same flag. In that case the set must win. To provoke this, the bench drives a clear of the segment flag every other cycle while the ring runs freely. The result is judged by counting rising edges on `irq`, which must equal the number of completed segments. The count of completed segments is derived from the peripheral writes seen on the memory port. If the clear were allowed to win in even one of these cycles, an interrupt would go missing and the count would fall short.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DSC0, ST_DSC1, ST_DSC2, ST_GATE, ST_READ, ST_WRITE
  } eng_state_t;

  localparam logic [2:0] SEL_MODE  = 3'd0;
  localparam logic [2:0] SEL_STAT  = 3'd1;
  localparam logic [2:0] SEL_FIRST = 3'd2;
  localparam logic [2:0] SEL_SRC   = 3'd3;
  localparam logic [2:0] SEL_DST   = 3'd4;
  localparam logic [2:0] SEL_LEFT  = 3'd5;

  localparam int MB_ABORT = 0;
  localparam int MB_PACE  = 1;
  localparam int MB_SEGIE = 2;
  localparam int MB_ERRIE = 3;
  localparam int MB_SHOLD = 4;
  localparam int MB_DHOLD = 5;
  localparam int MB_GO    = 12;

  localparam int SB_SEG  = 0;
  localparam int SB_LOOP = 1;
  localparam int SB_PERR = 2;
  localparam int SB_TERR = 3;

  function automatic logic [31:0] unit_bytes(input logic [1:0] lg);
    return 32'd1 << lg;
  endfunction

  function automatic logic [31:0] burst_bytes(input logic [3:0] lg);
    return 32'd1 << lg;
  endfunction

  // descriptor sanity: count nonzero, whole units, next pointer aligned
  function automatic logic seg_bad(input logic [31:0] cnt, input logic [1:0] lg,
                                   input logic [4:0] nxt_lo);
    return (cnt == 32'd0) || ((cnt & (unit_bytes(lg) - 32'd1)) != 32'd0) ||
           (nxt_lo != 5'd0);
  endfunction

endpackage

// File: rtl/chdma_regs.sv
module chdma_regs
  import chdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              start,
  output logic              abort,
  output logic              pace_fault,
  output logic              pace,
  output logic              shold,
  output logic              dhold,
  output logic [1:0]        ulog,
  output logic [3:0]        blog,
  output logic [ADDR_W-1:0] first_addr,
  input  logic              busy,
  input  logic              seg_evt,
  input  logic              loop_evt,
  input  logic              perr_evt,
  input  logic              terr_evt,
  input  logic [ADDR_W-1:0] cur_src,
  input  logic [ADDR_W-1:0] cur_dst,
  input  logic [31:0]       left
);

  logic [11:1] mode_q;
  logic [3:0]  flags;
  logic [3:0]  set_vec;
  logic [3:0]  clr_vec;
  logic        mode_wr;
  logic        stat_wr;
  logic        unused_bits;

  assign mode_wr    = reg_we && (reg_sel == SEL_MODE);
  assign stat_wr    = reg_we && (reg_sel == SEL_STAT);
  assign abort      = mode_wr && reg_wdata[MB_ABORT];
  assign start      = mode_wr && !reg_wdata[MB_ABORT] && reg_wdata[MB_GO] && !busy;
  assign pace_fault = mode_wr && !reg_wdata[MB_ABORT] && reg_wdata[MB_PACE] &&
                      busy && (left != 32'd0);
  assign unused_bits = ^reg_wdata[31:13];

  assign pace  = mode_q[MB_PACE];
  assign shold = mode_q[MB_SHOLD];
  assign dhold = mode_q[MB_DHOLD];
  assign ulog  = mode_q[7:6];
  assign blog  = mode_q[11:8];

  assign set_vec = {terr_evt, perr_evt | pace_fault, loop_evt, seg_evt};
  assign clr_vec = stat_wr ? reg_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      flags      <= '0;
      first_addr <= '0;
    end else begin
      if (mode_wr) mode_q <= reg_wdata[11:1];
      if (reg_we && (reg_sel == SEL_FIRST)) first_addr <= reg_wdata[ADDR_W-1:0];
      flags <= (flags & ~clr_vec) | set_vec;   // set wins over clear
    end
  end

  assign irq = (flags[SB_SEG] && mode_q[MB_SEGIE]) ||
               ((flags[SB_PERR] || flags[SB_TERR]) && mode_q[MB_ERRIE]);

  always_comb begin
    unique case (reg_sel)
      SEL_MODE:  reg_rdata = {20'd0, mode_q, 1'b0};
      SEL_STAT:  reg_rdata = {27'd0, busy, flags};
      SEL_FIRST: reg_rdata = 32'(first_addr);
      SEL_SRC:   reg_rdata = 32'(cur_src);
      SEL_DST:   reg_rdata = 32'(cur_dst);
      SEL_LEFT:  reg_rdata = left;
      default:   reg_rdata = 32'd0;
    endcase
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_evt |=> flags[SB_SEG]);

  assert_w1c_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[3:0] == 4'd0 && set_vec == 4'd0) |=> $stable(flags));

  assert_fault_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pace_fault |=> flags[SB_PERR]);

endmodule

// File: rtl/chdma_engine.sv
module chdma_engine
  import chdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              halt_req,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic              pace,
  input  logic              shold,
  input  logic              dhold,
  input  logic [1:0]        ulog,
  input  logic [3:0]        blog,
  input  logic              periph_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              busy,
  output logic              seg_evt,
  output logic              loop_evt,
  output logic              perr_evt,
  output logic              terr_evt,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [31:0]       left
);

  eng_state_t        state;
  logic [ADDR_W-1:0] dsc;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] src;
  logic [ADDR_W-1:0] dst;
  logic [31:0]       burst;
  logic [63:0]       hold_data;
  logic [31:0]       ub;
  logic [31:0]       bb;
  logic              beat_done;
  logic              last_unit;
  logic              first_bad;

  assign ub        = unit_bytes(ulog);
  assign bb        = burst_bytes(blog);
  assign busy      = (state != ST_IDLE);
  assign first_bad = (first_addr[4:0] != 5'd0);

  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_size = 2'd3;
    mem_addr = dsc;
    unique case (state)
      ST_DSC0:  mem_addr = dsc;
      ST_DSC1:  mem_addr = dsc + ADDR_W'(8);
      ST_DSC2:  mem_addr = dsc + ADDR_W'(16);
      ST_READ:  begin mem_addr = src; mem_size = ulog; end
      ST_WRITE: begin mem_addr = dst; mem_size = ulog; mem_we = 1'b1; end
      default:  mem_req = 1'b0;
    endcase
  end
  assign mem_wdata = hold_data;

  assign beat_done = mem_req && mem_ack && !mem_err;
  assign terr_evt  = mem_req && mem_ack && mem_err;
  assign last_unit = (left == ub);
  assign seg_evt   = (state == ST_WRITE) && beat_done && last_unit;
  assign loop_evt  = seg_evt && (nxt == first_addr);
  assign perr_evt  = ((state == ST_IDLE) && start && first_bad) ||
                     ((state == ST_DSC2) && beat_done && seg_bad(left, ulog, mem_rdata[4:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dsc       <= '0;
      nxt       <= '0;
      src       <= '0;
      dst       <= '0;
      burst     <= '0;
      hold_data <= '0;
      cur_src   <= '0;
      cur_dst   <= '0;
      left      <= '0;
    end else if (abort || halt_req || terr_evt || perr_evt) begin
      state <= ST_IDLE;
      left  <= '0;
      burst <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          dsc   <= first_addr;
          state <= ST_DSC0;
        end
        ST_DSC0: if (beat_done) begin
          src   <= mem_rdata[ADDR_W-1:0];
          dst   <= mem_rdata[32 +: ADDR_W];
          state <= ST_DSC1;
        end
        ST_DSC1: if (beat_done) begin
          left  <= mem_rdata[31:0];
          state <= ST_DSC2;
        end
        ST_DSC2: if (beat_done) begin
          nxt   <= mem_rdata[ADDR_W-1:0];
          burst <= '0;
          state <= ST_GATE;
        end
        ST_GATE: if (!pace || periph_req) state <= ST_READ;
        ST_READ: if (beat_done) begin
          hold_data <= mem_rdata;
          cur_src   <= src;
          state     <= ST_WRITE;
        end
        ST_WRITE: if (beat_done) begin
          cur_dst <= dst;
          if (!shold) src <= src + ADDR_W'(ub);
          if (!dhold) dst <= dst + ADDR_W'(ub);
          left <= left - ub;
          if (last_unit) begin
            dsc   <= nxt;
            state <= ST_DSC0;
          end else if (burst + ub >= bb) begin
            burst <= '0;
            state <= ST_GATE;
          end else begin
            burst <= burst + ub;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !mem_req);

  assert_pace_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE && pace && !periph_req) |=> !mem_req);

  assert_seg_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_evt |=> (left == 32'd0));

  assert_src_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && beat_done && shold) |=> $stable(src));

  assert_perr_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_evt || halt_req) |=> !busy);

  assert_terr_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    terr_evt |=> !mem_req);

endmodule

// File: rtl/chdma_channel.sv
module chdma_channel
  import chdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);

  logic              start, abort, pace_fault, pace, shold, dhold, busy;
  logic              seg_evt, loop_evt, perr_evt, terr_evt;
  logic [1:0]        ulog;
  logic [3:0]        blog;
  logic [ADDR_W-1:0] first_addr, cur_src, cur_dst;
  logic [31:0]       left;

  chdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .start(start), .abort(abort), .pace_fault(pace_fault), .pace(pace),
    .shold(shold), .dhold(dhold), .ulog(ulog), .blog(blog),
    .first_addr(first_addr), .busy(busy), .seg_evt(seg_evt),
    .loop_evt(loop_evt), .perr_evt(perr_evt), .terr_evt(terr_evt),
    .cur_src(cur_src), .cur_dst(cur_dst), .left(left)
  );

  chdma_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .halt_req(pace_fault), .first_addr(first_addr), .pace(pace),
    .shold(shold), .dhold(dhold), .ulog(ulog), .blog(blog),
    .periph_req(periph_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .busy(busy), .seg_evt(seg_evt), .loop_evt(loop_evt),
    .perr_evt(perr_evt), .terr_evt(terr_evt), .cur_src(cur_src),
    .cur_dst(cur_dst), .left(left)
  );

endmodule

// File: tb/chdma_channel_test.sv
module chdma_channel_test;

  localparam logic [31:0] TX_PORT = 32'h3F0;
  localparam logic [31:0] RX_PORT = 32'h3F8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        mem_req, mem_we, mem_ack, mem_err, irq;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  logic [7:0]  mem [0:1023];
  logic [15:0] rx_val = 16'hA000;
  logic        err_on = 1'b0;
  logic [31:0] err_addr = 32'd0;
  logic [31:0] exp_q [$];
  int nchk = 0, nfail = 0;
  int tx_seen = 0, rx_reads = 0, irq_rises = 0, req_seen = 0;
  logic irq_prev = 1'b0;

  always #4 clk = ~clk;

  chdma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
  );

  // memory model: always ready, little-endian bytes, one peripheral source
  assign mem_ack = mem_req;
  assign mem_err = mem_req && err_on && (mem_addr == err_addr);

  always_comb begin
    mem_rdata = 64'd0;
    if (mem_addr == RX_PORT) mem_rdata = {48'd0, rx_val};
    else
      for (int b = 0; b < 8; b++)
        if (b < (1 << mem_size)) mem_rdata[8*b +: 8] = mem[(int'(mem_addr[9:0]) + b) % 1024];
  end

  always @(posedge clk) begin
    if (mem_req && !mem_err) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (b < (1 << mem_size)) mem[(int'(mem_addr[9:0]) + b) % 1024] <= mem_wdata[8*b +: 8];
      end else if (mem_addr == RX_PORT) rx_val <= rx_val + 16'd1;
    end
  end

  // monitor: scoreboard of peripheral writes, request and interrupt counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we && mem_addr == TX_PORT && !mem_err) begin
        tx_seen++;
        nchk++;
        if (exp_q.size() == 0) begin
          nfail++;
          $display("FAIL R2 data order actual=%h expected=none", mem_wdata[31:0]);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (mem_wdata[31:0] !== e) begin
            nfail++;
            $display("FAIL R2 data order actual=%h expected=%h", mem_wdata[31:0], e);
          end
        end
      end
      if (mem_req && !mem_we && mem_addr == RX_PORT) rx_reads++;
      if (mem_req) req_seen++;
      if (irq && !irq_prev) irq_rises++;
    end
    irq_prev = irq;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] get32(input int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [31:0] n);
    put32(a, s); put32(a + 4, d); put32(a + 8, c); put32(a + 12, 0);
    put32(a + 16, n); put32(a + 20, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; periph_req = 1'b0; err_on = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    tx_seen = 0; rx_reads = 0; irq_rises = 0; req_seen = 0;
    rst_n = 1'b1;
  endtask

  task automatic bad_case(input string tag, input logic [31:0] first);
    logic [31:0] v;
    do_reset();
    reg_write(3'd2, first);
    reg_write(3'd0, 32'h1088);
    repeat (12) @(negedge clk);
    reg_read(3'd1, v);
    chk({tag, " program error flag, halted"}, v, 32'h4);
    chk({tag, " error irq"}, {31'd0, irq}, 32'd1);
    chk({tag, " no data moved"}, tx_seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w;
    for (int i = 0; i < 1024; i++) mem[i] = 8'd0;
    for (int i = 0; i < 32; i++) mem[256 + i] = 8'(i * 7 + 3);
    do_reset();

    // R1 reset state
    chk("R1 mem_req idle", {31'd0, mem_req}, 0);
    chk("R1 irq low", {31'd0, irq}, 0);
    reg_read(3'd0, v); chk("R1 mode zero", v, 0);
    reg_read(3'd1, v); chk("R1 status zero", v, 0);
    reg_read(3'd3, v); chk("R1 R9 cur src zero", v, 0);
    reg_read(3'd4, v); chk("R1 R9 cur dst zero", v, 0);
    reg_read(3'd5, v); chk("R1 left zero", v, 0);

    // R2 R3 R4 R7 R8: two-descriptor ring, memory to held peripheral address
    put_desc(32'h000, 32'h100, TX_PORT, 16, 32'h020);
    put_desc(32'h020, 32'h110, TX_PORT, 16, 32'h000);
    for (int lp = 0; lp < 4; lp++)
      for (int k = 0; k < 8; k++) exp_q.push_back(get32(256 + 4 * k));
    reg_write(3'd2, 32'h000);
    reg_write(3'd0, 32'h14A4);
    while (tx_seen < 20) reg_write(3'd1, 32'h1);   // clear races with segment ends (R7)
    reg_write(3'd0, 32'h1);                        // abort (R8)
    w = tx_seen;
    req_seen = 0;
    repeat (20) @(negedge clk);
    chk("R8 no requests after abort", req_seen, 0);
    chk("R2 ring ran past one pass", {31'd0, (w >= 20 && w <= 32)}, 1);
    chk("R3 R7 one irq per segment", irq_rises, w / 4);
    reg_read(3'd1, v); chk("R4 R12 loop flag set, busy low", v & 32'h12, 32'h2);
    reg_read(3'd5, v); chk("R8 left cleared", v, 0);
    reg_read(3'd4, v); chk("R5 R9 dst held at port", v, TX_PORT);
    reg_read(3'd3, v); chk("R9 cur src last read", v, 32'h100 + ((w - 1) % 8) * 4);

    // R6 R5 R9 R10 R12: paced capture from held source
    do_reset();
    put_desc(32'h040, RX_PORT, 32'h200, 8, 32'h040);
    reg_write(3'd2, 32'h040);
    reg_write(3'd0, 32'h1256);
    repeat (30) @(negedge clk);
    chk("R6 no reads without request", rx_reads, 0);
    reg_read(3'd1, v); chk("R12 busy while stalled", v, 32'h10);
    reg_read(3'd3, v); chk("R9 src zero before transfer", v, 0);
    reg_read(3'd4, v); chk("R9 dst zero before transfer", v, 0);
    reg_read(3'd0, v); chk("R5 mode readback", v, 32'h0256);
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 one burst of two units", rx_reads, 2);
    reg_read(3'd5, v); chk("R6 bytes left", v, 4);
    chk("R5 captured halfwords", get32(32'h200), 32'hA001A000);
    reg_read(3'd3, v); chk("R5 R9 src held", v, RX_PORT);
    reg_read(3'd4, v); chk("R9 dst last write", v, 32'h202);
    reg_write(3'd0, 32'h0256);                     // pacing with count pending
    reg_read(3'd1, v); chk("R10 pacing fault halts", v, 32'h4);
    chk("R10 no irq without error enable", {31'd0, irq}, 0);
    reg_write(3'd1, 32'h0);
    reg_read(3'd1, v); chk("R7 zero write keeps flag", v, 32'h4);
    reg_write(3'd1, 32'h4);
    reg_read(3'd1, v); chk("R7 one write clears flag", v, 32'h0);

    // R10 descriptor and address faults
    put_desc(32'h060, 32'h100, TX_PORT, 0, 32'h060);
    bad_case("R10 zero count", 32'h060);
    reg_write(3'd1, 32'h4);
    chk("R10 irq drops after clear", {31'd0, irq}, 0);
    put_desc(32'h080, 32'h100, TX_PORT, 6, 32'h080);
    bad_case("R10 partial unit", 32'h080);
    put_desc(32'h0C0, 32'h100, TX_PORT, 4, 32'h0C4);
    bad_case("R10 unaligned next", 32'h0C0);
    bad_case("R10 unaligned first", 32'h0E4);

    // R11 transfer error on the second read
    do_reset();
    put_desc(32'h0A0, 32'h150, TX_PORT, 8, 32'h0A0);
    for (int i = 0; i < 8; i++) mem[32'h150 + i] = 8'(8'h51 + i);
    exp_q.push_back(get32(32'h150));
    err_on = 1'b1; err_addr = 32'h154;
    reg_write(3'd2, 32'h0A0);
    reg_write(3'd0, 32'h10A8);
    repeat (20) @(negedge clk);
    reg_read(3'd1, v); chk("R11 transfer error, halted", v, 32'h8);
    chk("R11 error irq", {31'd0, irq}, 1);
    chk("R11 only first unit written", tx_seen, 1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule